// File: doc/BRIEF.md
# Sideband Request Formatter

This block takes one sideband transaction at a time from a valid/ready request port and turns it into a byte stream for a sideband transmit engine. A request carries a 4-bit request code, a 20-bit target address, a payload size of up to 16 bytes (the size field can carry larger values, which are refused) and a flat payload buffer. The block builds a four-byte header, sends it, and sends the payload after it for writes. It then waits for the reply from the engine and reduces that reply to a result code, a reply nibble, a byte count and the returned data.

The controller is a four-state machine. In IDLE it accepts a request. A request that is too long or of an unknown kind goes straight to DONE (transition IDLE->DONE). Any other request goes to SEND (IDLE->SEND). SEND puts out one byte each time the engine takes one. After the last byte it moves to WAIT (SEND->WAIT). WAIT holds until a reply arrives (WAIT->DONE). DONE presents the result until it is consumed, then returns to IDLE (DONE->IDLE). Only one transaction is in flight at a time.

Top module: `sideband_req_fmt`

## Requirements
- R1: A request whose size is greater than 16 sends no byte and ends with result code 4 (too big), count 0 and reply 0. This check comes before the kind check.
- R2: Header byte 0 is address bits 7:0. Header byte 1 is address bits 15:8. Header byte 2 holds the full 4-bit request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R3: Bits 3:0 of header byte 3 are the size minus one, or 0 when the size is 0.
- R4: Bits 7:4 of header byte 3 are 3 when the size is 0. Otherwise they are the low 4 bits of the transmitted length: 4 plus the size for writes, and 4 for reads. A 16-byte write therefore gives 4 and a 12-byte write gives 0.
- R5: A write sends the 4 header bytes and then payload bytes 0 to size-1, where payload byte k is req_data[8k+7:8k]. A read sends only the 4 header bytes, and this includes zero-length reads. tx_first marks the first byte and tx_last marks the final byte.
- R6: Reply status 1, 2 and 3 give result codes 1 (timeout), 2 (flags not zero) and 3 (error). Each of them has count 0, reply 0 and all-zero data.
- R7: Any other status is a success. It gives result code 0, and the reply nibble is bits 7:4 of the acknowledge byte.
- R8: A successful read reports the smaller of the received length and the requested size. Data byte k is rsp_data byte k for k below that count and 0 above it. A successful write reports its size as the count, with zero data.
- R9: Bit 2 of the request code (continue-transaction) is ignored when the kind is decided. Codes 0 and 8 are writes, and codes 1 and 9 are reads. Any other code sends nothing and ends with result code 5 (invalid).
- R10: req_ready is high only in IDLE. It falls in the cycle after a request is accepted and rises again in the cycle after the result is consumed (res_valid and res_ready both high).
- R11: While tx_valid is high and tx_ready is low, tx_data and tx_last hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_code | input | 4 | Request code |
| req_addr | input | 20 | Target address |
| req_size | input | 5 | Payload size in bytes |
| req_data | input | 128 | Payload, byte k at bits 8k+7:8k |
| tx_valid | output | 1 | Stream byte present |
| tx_ready | input | 1 | Engine takes the byte |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of the transaction |
| tx_last | output | 1 | Final byte of the transaction |
| rsp_valid | input | 1 | Reply present (one cycle) |
| rsp_status | input | 8 | Reply status byte |
| rsp_ack | input | 8 | Acknowledge byte |
| rsp_len | input | 5 | Bytes received |
| rsp_data | input | 128 | Received bytes |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumed |
| res_code | output | 3 | 0 ok, 1 timeout, 2 flags, 3 error, 4 too big, 5 invalid |
| res_reply | output | 4 | Reply nibble |
| res_count | output | 5 | Byte count |
| res_data | output | 128 | Returned data |

## Verification
Some properties are checked by assertions on every cycle. These are the ready handshake (ready drops after acceptance and comes back after consumption), byte hold under back-pressure, the immediate refusal of oversize requests, the markers appearing only with a valid byte, and the rule that error results carry no count or reply. Other behaviour needs the bench's scenarios to be seen: the exact header bytes, the length nibble for each size (zero, 12 and 16 bytes), the byte order, count clipping, masking of the returned data, and the kind decision with the continue bit set or with an unknown code.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
    localparam int ADDR_W = 20;
    localparam logic [3:0] CODE_CONT_BIT = 4'b0100;
    localparam logic [3:0] CODE_BUS_WR   = 4'h0;
    localparam logic [3:0] CODE_BUS_RD   = 4'h1;
    localparam logic [3:0] CODE_NAT_WR   = 4'h8;
    localparam logic [3:0] CODE_NAT_RD   = 4'h9;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_TIMEOUT = 3'd1,
        RES_FLAGS   = 3'd2,
        RES_ERROR   = 3'd3,
        RES_TOO_BIG = 3'd4,
        RES_INVALID = 3'd5
    } res_code_e;

    typedef enum logic [1:0] {
        KIND_WRITE,
        KIND_READ,
        KIND_BAD
    } req_kind_e;
endpackage

// File: rtl/sbf_header.sv
module sbf_header
    import sbf_pkg::*;
#(
    parameter int SIZE_W    = 5,
    parameter int MAX_BYTES = 16,
    localparam int LEN_W    = SIZE_W + 1
) (
    input  logic [3:0]        code,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output req_kind_e         kind,
    output logic              oversize,
    output logic [3:0][7:0]   hdr,
    output logic [LEN_W-1:0]  total_len
);
    logic [3:0]       base_code;
    logic [LEN_W-1:0] wr_len;
    logic [3:0]       len_hi;
    logic [3:0]       len_lo;

    always_comb begin
        base_code = code & ~CODE_CONT_BIT;
        unique case (base_code)
            CODE_BUS_WR, CODE_NAT_WR: kind = KIND_WRITE;
            CODE_BUS_RD, CODE_NAT_RD: kind = KIND_READ;
            default:                  kind = KIND_BAD;
        endcase
        oversize  = size > SIZE_W'(MAX_BYTES);
        wr_len    = LEN_W'(4) + LEN_W'(size);
        total_len = (kind == KIND_WRITE) ? wr_len : LEN_W'(4);
        len_lo    = (size == '0) ? 4'd0 : 4'(size - 1'b1);
        if (size == '0)
            len_hi = 4'd3;
        else if (kind == KIND_WRITE)
            len_hi = wr_len[3:0];
        else
            len_hi = 4'd4;
        hdr[0] = addr[7:0];
        hdr[1] = addr[15:8];
        hdr[2] = {code, addr[19:16]};
        hdr[3] = {len_hi, len_lo};
    end
endmodule

// File: rtl/sbf_reply.sv
module sbf_reply
    import sbf_pkg::*;
#(
    parameter int SIZE_W    = 5,
    parameter int MAX_BYTES = 16,
    localparam int DATA_W   = MAX_BYTES * 8
) (
    input  logic              is_read,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [7:0]        status,
    input  logic [7:0]        ack,
    input  logic [SIZE_W-1:0] rsp_len,
    input  logic [DATA_W-1:0] rsp_data,
    output res_code_e         code,
    output logic [3:0]        reply,
    output logic [SIZE_W-1:0] count,
    output logic [DATA_W-1:0] data
);
    logic              ok;
    logic [SIZE_W-1:0] clipped;

    always_comb begin
        unique case (status)
            8'd1:    code = RES_TIMEOUT;
            8'd2:    code = RES_FLAGS;
            8'd3:    code = RES_ERROR;
            default: code = RES_OK;
        endcase
        ok      = (code == RES_OK);
        reply   = ok ? ack[7:4] : 4'd0;
        clipped = (rsp_len > req_size) ? req_size : rsp_len;
        if (!ok)
            count = '0;
        else if (is_read)
            count = clipped;
        else
            count = req_size;
    end

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_mask
        assign data[g*8 +: 8] = (ok && is_read && (SIZE_W'(g) < count))
                                ? rsp_data[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sideband_req_fmt.sv
module sideband_req_fmt
    import sbf_pkg::*;
#(
    parameter int SIZE_W    = 5,
    parameter int MAX_BYTES = 16,
    localparam int LEN_W    = SIZE_W + 1,
    localparam int PIDX_W   = $clog2(MAX_BYTES),
    localparam int DATA_W   = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_code,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_status,
    input  logic [7:0]        rsp_ack,
    input  logic [SIZE_W-1:0] rsp_len,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [2:0]        res_code,
    output logic [3:0]        res_reply,
    output logic [SIZE_W-1:0] res_count,
    output logic [DATA_W-1:0] res_data
);
    typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_DONE} state_e;

    state_e                      state_q, state_d;
    logic [LEN_W-1:0]            idx_q, last_q;
    logic [3:0][7:0]             hdr_q;
    logic [MAX_BYTES-1:0][7:0]   pay_q;
    logic [SIZE_W-1:0]           size_q;
    req_kind_e                   kind_q;
    res_code_e                   rcode_q;
    logic [3:0]                  rreply_q;
    logic [SIZE_W-1:0]           rcount_q;
    logic [DATA_W-1:0]           rdata_q;

    req_kind_e                   h_kind;
    logic                        h_over;
    logic [3:0][7:0]             h_hdr;
    logic [LEN_W-1:0]            h_len;
    res_code_e                   p_code;
    logic [3:0]                  p_reply;
    logic [SIZE_W-1:0]           p_count;
    logic [DATA_W-1:0]           p_data;
    logic                        accept;
    logic [PIDX_W-1:0]           pay_sel;

    sbf_header #(.SIZE_W(SIZE_W), .MAX_BYTES(MAX_BYTES)) u_hdr (
        .code(req_code), .addr(req_addr), .size(req_size),
        .kind(h_kind), .oversize(h_over), .hdr(h_hdr), .total_len(h_len)
    );

    sbf_reply #(.SIZE_W(SIZE_W), .MAX_BYTES(MAX_BYTES)) u_rsp (
        .is_read(kind_q == KIND_READ), .req_size(size_q),
        .status(rsp_status), .ack(rsp_ack), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .code(p_code), .reply(p_reply), .count(p_count), .data(p_data)
    );

    assign accept = req_valid && (state_q == S_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid)
                        state_d = (h_over || h_kind == KIND_BAD) ? S_DONE : S_SEND;
            S_SEND: if (tx_ready && idx_q == last_q) state_d = S_WAIT;
            S_WAIT: if (rsp_valid) state_d = S_DONE;
            S_DONE: if (res_ready) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            idx_q    <= '0;
            last_q   <= '0;
            hdr_q    <= '0;
            pay_q    <= '0;
            size_q   <= '0;
            kind_q   <= KIND_WRITE;
            rcode_q  <= RES_OK;
            rreply_q <= '0;
            rcount_q <= '0;
            rdata_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                hdr_q    <= h_hdr;
                pay_q    <= req_data;
                size_q   <= req_size;
                kind_q   <= h_kind;
                idx_q    <= '0;
                last_q   <= h_len - 1'b1;
                rreply_q <= '0;
                rcount_q <= '0;
                rdata_q  <= '0;
                rcode_q  <= h_over ? RES_TOO_BIG :
                            (h_kind == KIND_BAD) ? RES_INVALID : RES_OK;
            end
            if (state_q == S_SEND && tx_ready)
                idx_q <= idx_q + 1'b1;
            if (state_q == S_WAIT && rsp_valid) begin
                rcode_q  <= p_code;
                rreply_q <= p_reply;
                rcount_q <= p_count;
                rdata_q  <= p_data;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        tx_valid  = 1'b0;
        res_valid = 1'b0;
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_SEND: tx_valid  = 1'b1;
            S_WAIT: ;
            S_DONE: res_valid = 1'b1;
        endcase
        pay_sel   = PIDX_W'(idx_q - LEN_W'(4));
        tx_data   = (idx_q < LEN_W'(4)) ? hdr_q[idx_q[1:0]] : pay_q[pay_sel];
        tx_first  = tx_valid && (idx_q == '0);
        tx_last   = tx_valid && (idx_q == last_q);
        res_code  = rcode_q;
        res_reply = rreply_q;
        res_count = rcount_q;
        res_data  = rdata_q;
    end

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_ready_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> req_ready);
    p_hold_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    p_reject_long_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size > SIZE_W'(MAX_BYTES))
        |=> (res_valid && !tx_valid && res_code == 3'd4));
    p_err_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code != 3'd0) |-> (res_count == '0 && res_reply == 4'd0));
    p_marks_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_first || tx_last) |-> tx_valid);
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_count <= SIZE_W'(MAX_BYTES)));
endmodule

// File: tb/sideband_req_fmt_tb.sv
module sideband_req_fmt_tb;
    localparam int N = 15;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         req_valid = 0, req_ready;
    logic [3:0]   req_code = 0;
    logic [19:0]  req_addr = 0;
    logic [4:0]   req_size = 0;
    logic [127:0] req_data = 0;
    logic         tx_valid, tx_ready = 0, tx_first, tx_last;
    logic [7:0]   tx_data;
    logic         rsp_valid = 0;
    logic [7:0]   rsp_status = 0, rsp_ack = 0;
    logic [4:0]   rsp_len = 0;
    logic [127:0] rsp_data = 0;
    logic         res_valid, res_ready = 0;
    logic [2:0]   res_code;
    logic [3:0]   res_reply;
    logic [4:0]   res_count;
    logic [127:0] res_data;

    sideband_req_fmt u_dut (.*);

    localparam logic [3:0]  V_CODE [N] = '{4'h8,4'h9,4'h9,4'h1,4'h0,4'h5,4'h4,4'h8,4'h9,4'h8,4'h9,4'h8,4'h2,4'hA,4'hD};
    localparam logic [19:0] V_ADDR [N] = '{20'h12345,20'hABCDE,20'h00F0F,20'h80001,20'h00050,20'h7FFFF,20'h00A00,
                                          20'h33333,20'h11111,20'h22222,20'h44444,20'h55555,20'h66666,20'h77777,20'h0C0DE};
    localparam logic [4:0]  V_SIZE [N] = '{5'd3,5'd16,5'd4,5'd8,5'd0,5'd0,5'd16,5'd12,5'd2,5'd1,5'd6,5'd17,5'd2,5'd20,5'd1};
    localparam logic [7:0]  V_STAT [N] = '{0,0,0,0,0,0,0,0,1,2,3,0,0,0,0};
    localparam logic [7:0]  V_ACK  [N] = '{8'h00,8'h20,8'h10,8'h00,8'h00,8'h00,8'h00,8'h00,8'hF0,8'h30,8'h50,0,0,0,8'hF0};
    localparam logic [4:0]  V_LEN  [N] = '{5'd0,5'd16,5'd10,5'd5,5'd0,5'd3,5'd0,5'd0,5'd2,5'd0,5'd6,0,0,0,5'd1};
    localparam logic [2:0]  E_CODE [N] = '{0,0,0,0,0,0,0,0,1,2,3,4,5,4,0};
    localparam logic [4:0]  E_CNT  [N] = '{5'd3,5'd16,5'd4,5'd5,0,0,5'd16,5'd12,0,0,0,0,0,0,5'd1};
    localparam logic [3:0]  E_REP  [N] = '{0,4'd2,4'd1,0,0,0,0,0,0,0,0,0,0,0,4'hF};

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pay_byte(input int v, input int k);
        return 8'((v << 4) ^ k ^ 8'h5A);
    endfunction
    function automatic logic [7:0] rsp_byte(input int v, input int k);
        return 8'(8'hC0 + k + v);
    endfunction
    function automatic bit is_wr(input logic [3:0] c);
        return ((c & 4'hB) == 4'h0) || ((c & 4'hB) == 4'h8);
    endfunction
    function automatic bit is_rd(input logic [3:0] c);
        return ((c & 4'hB) == 4'h1) || ((c & 4'hB) == 4'h9);
    endfunction
    function automatic logic [7:0] exp_byte(input int v, input int i);
        logic [3:0] hi, lo;
        int sz;
        sz = int'(V_SIZE[v]);
        lo = (sz == 0) ? 4'd0 : 4'(sz - 1);
        hi = (sz == 0) ? 4'd3 : (is_wr(V_CODE[v]) ? 4'(4 + sz) : 4'd4);
        case (i)
            0: return V_ADDR[v][7:0];
            1: return V_ADDR[v][15:8];
            2: return {V_CODE[v], V_ADDR[v][19:16]};
            3: return {hi, lo};
            default: return pay_byte(v, i - 4);
        endcase
    endfunction

    task automatic run_vec(input int v);
        int total, sent, err;
        bit responded, stall_prev, stall_on;
        logic [7:0] prev;
        logic [127:0] exp_data;
        err = (V_SIZE[v] > 5'd16) ? 4 : (!is_wr(V_CODE[v]) && !is_rd(V_CODE[v])) ? 5 : 0;
        total = (err != 0) ? 0 : is_wr(V_CODE[v]) ? 4 + int'(V_SIZE[v]) : 4;
        stall_on = v[0];
        @(negedge clk);
        req_code = V_CODE[v]; req_addr = V_ADDR[v]; req_size = V_SIZE[v];
        for (int k = 0; k < 16; k++) req_data[k*8 +: 8] = pay_byte(v, k);
        req_valid = 1'b1;
        check(req_ready == 1'b1, $sformatf("R10 ready idle v%0d", v), req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, $sformatf("R10 ready low after accept v%0d", v), req_ready, 0);
        sent = 0; responded = 0; stall_prev = 0; prev = 0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (res_valid) break;
            if (total != 0 && sent == total && !responded) begin
                check(tx_valid == 1'b0 && req_ready == 1'b0, $sformatf("R5 R10 quiet wait v%0d", v), {tx_valid, req_ready}, 0);
                rsp_status = V_STAT[v]; rsp_ack = V_ACK[v]; rsp_len = V_LEN[v];
                for (int k = 0; k < 16; k++) rsp_data[k*8 +: 8] = rsp_byte(v, k);
                rsp_valid = 1'b1; responded = 1;
                tx_ready = 1'b0;
            end else begin
                rsp_valid = 1'b0;
                if (tx_valid) begin
                    if (sent >= total)
                        check(0, $sformatf("R1 R5 R9 extra byte v%0d", v), sent, total);
                    if (stall_prev)
                        check(tx_data == prev, $sformatf("R11 hold v%0d", v), tx_data, prev);
                    tx_ready = !(stall_on && (cyc % 2 == 0));
                    if (tx_ready) begin
                        check(tx_data == exp_byte(v, sent), $sformatf("R2 R3 R4 R5 byte %0d v%0d", sent, v),
                              tx_data, exp_byte(v, sent));
                        check(tx_first == (sent == 0) && tx_last == (sent == total - 1),
                              $sformatf("R5 markers byte %0d v%0d", sent, v), {tx_first, tx_last},
                              {sent == 0, sent == total - 1});
                        sent++; stall_prev = 0;
                    end else begin
                        stall_prev = 1; prev = tx_data;
                    end
                end else if (sent < total) begin
                    check(0, $sformatf("R5 missing byte v%0d", v), sent, total);
                end
            end
            @(negedge clk);
        end
        rsp_valid = 1'b0; tx_ready = 1'b0;
        check(sent == total, $sformatf("R1 R5 R9 byte count v%0d", v), sent, total);
        check(res_valid == 1'b1, $sformatf("R6 result present v%0d", v), res_valid, 1);
        check(res_code == E_CODE[v], $sformatf("R1 R6 R7 R9 code v%0d", v), res_code, E_CODE[v]);
        check(res_count == E_CNT[v], $sformatf("R6 R8 count v%0d", v), res_count, E_CNT[v]);
        check(res_reply == E_REP[v], $sformatf("R6 R7 reply v%0d", v), res_reply, E_REP[v]);
        exp_data = '0;
        if (E_CODE[v] == 0 && is_rd(V_CODE[v]))
            for (int k = 0; k < 16; k++) if (k < int'(E_CNT[v])) exp_data[k*8 +: 8] = rsp_byte(v, k);
        check(res_data == exp_data, $sformatf("R8 data v%0d", v), res_data, exp_data);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(req_ready == 1'b1 && res_valid == 1'b0, $sformatf("R10 ready after consume v%0d", v),
              {req_ready, res_valid}, 2'b10);
    endtask

    initial begin
        #(8 * 150000);
        check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && tx_valid == 1'b0 && res_valid == 1'b0, "R10 reset state",
              {req_ready, tx_valid, res_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && tx_valid == 1'b0 && res_valid == 1'b0, "R10 idle after reset",
              {req_ready, tx_valid, res_valid}, 3'b100);
        for (int v = 0; v < N; v++) run_vec(v);

        // Directed: refused request held valid while its result waits; nothing is taken or sent (R1, R10)
        @(negedge clk);
        req_code = 4'h8; req_size = 5'd31; req_addr = 20'h0; req_valid = 1'b1;
        @(negedge clk);
        req_size = 5'd2;
        for (int c = 0; c < 3; c++) begin
            check(res_valid && !req_ready && !tx_valid && res_code == 3'd4, "R1 R10 held while pending",
                  {res_valid, req_ready, tx_valid, res_code}, {3'b100, 3'd4});
            @(negedge clk);
        end
        req_valid = 1'b0;
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(req_ready && !tx_valid && !res_valid, "R10 back to idle", {req_ready, tx_valid, res_valid}, 3'b100);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule